// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit rearranges the elements of one vector register under a mask that carries one bit per element. In compress mode it gathers the source elements whose mask bit is set and writes them, in ascending order, into the low positions of the destination. It also reports how many there were, which is the vector length that the packed result has. In expand mode it does the inverse. Consecutive source elements, starting at element 0, are scattered to the destination positions whose mask bit is set. Every other position keeps the value the destination held before.

A single-cycle `start` pulse launches an operation. On that edge the unit captures the mode, the active length, the mask, the source vector and the prior destination contents. It then scans one element index per clock and raises `done` for one cycle when the scan has covered the active length. The mask is typically the result of an element-wise compare of two vectors. Producing the mask and doing arithmetic are left to the neighbouring units.

Top module: `vmask_permute`

## Requirements
- R1: In compress mode (`mode`=0), the k-th set mask bit below the active length, counted from element 0 upward, puts that source element at destination index k.
- R2: In compress mode, destination positions at or above the packed length keep their prior values.
- R3: `packed_len` equals the number of set mask bits at indices below the active length, in both modes, and is valid from the cycle in which `done` is high.
- R4: In expand mode (`mode`=1), source element k goes to the destination index that holds the k-th set mask bit below the active length.
- R5: In expand mode, destination positions whose mask bit is clear keep their prior values.
- R6: Mask bits at indices at or above the active length have no effect on the data or on `packed_len`.
- R7: `busy` is high from the cycle after `start` is accepted until the scan completes. `done` is a one-cycle pulse that appears exactly L+1 clocks after the accepting edge, where L is the active length, and `busy` is low while `done` is high.
- R8: A `start` pulse that arrives while `busy` is high is ignored, and the running operation finishes with its own configuration.
- R9: After reset, `busy`, `done` and `packed_len` are 0.
- R10: A requested length above the register size NELEM is treated as NELEM.
- R11: An all-zero mask gives `packed_len` 0 and leaves the whole destination unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted only when not busy |
| mode | input | 1 | 0 = compress, 1 = expand |
| vl | input | $clog2(NELEM)+1 | Requested active length |
| mask | input | NELEM | One bit per element, bit i belongs to element i |
| src_data | input | NELEM*DW | Source vector, element i in bits [i*DW +: DW] |
| dst_prior | input | NELEM*DW | Destination contents before the operation |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| dst_data | output | NELEM*DW | Resulting destination vector |
| packed_len | output | $clog2(NELEM)+1 | Set mask bits below the active length |

## Verification
The hardest case to reach from the ports is a second `start` that arrives while a scan is running and carries a different mode, mask, length and data. The unit has to drop it without disturbing the captured configuration or the partly written destination. The bench launches full-length scans and, one clock into each, pulses `start` with scrambled inputs. It then checks that the result matches the first request alone. The main sweep covers every mask of an 8-element configuration at every requested length, including lengths above the register size, in both modes.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  typedef enum logic {
    VMC_COMPRESS = 1'b0,
    VMC_EXPAND   = 1'b1
  } vmc_mode_e;
endpackage

// File: rtl/vmc_ctrl.sv
module vmc_ctrl
  import vmc_pkg::*;
#(
  parameter int NELEM = 64,
  localparam int IW = $clog2(NELEM),
  localparam int CW = IW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  vmc_mode_e        mode_in,
  input  logic [CW-1:0]    vl_in,
  input  logic [NELEM-1:0] mask_in,
  output logic             accept,
  output logic             wr_en,
  output logic [IW-1:0]    scan_idx,
  output logic [IW-1:0]    pack_idx,
  output vmc_mode_e        mode_q,
  output logic             busy,
  output logic             done,
  output logic [CW-1:0]    len_out
);
  localparam logic [CW-1:0] MAX_VL = CW'(NELEM);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CW-1:0]    scan_q, scan_d;
  logic [CW-1:0]    pack_q, pack_d;
  logic [CW-1:0]    len_q, len_d;
  logic [CW-1:0]    vl_q, vl_cap;
  logic [NELEM-1:0] mask_q;
  logic             last, step, bit_set;

  assign accept  = start & ~busy_q;
  assign last    = busy_q & (scan_q == vl_q);
  assign step    = busy_q & ~last;
  assign bit_set = step & mask_q[scan_q[IW-1:0]];
  assign vl_cap  = (vl_in > MAX_VL) ? MAX_VL : vl_in;

  always_comb begin
    busy_d = busy_q;
    scan_d = scan_q;
    pack_d = pack_q;
    len_d  = len_q;
    done_d = last;
    if (accept) begin
      busy_d = 1'b1;
      scan_d = '0;
      pack_d = '0;
    end else if (last) begin
      busy_d = 1'b0;
      len_d  = pack_q;
    end else if (step) begin
      scan_d = scan_q + ONE;
      if (bit_set) pack_d = pack_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      scan_q <= '0;
      pack_q <= '0;
      len_q  <= '0;
      vl_q   <= '0;
      mask_q <= '0;
      mode_q <= VMC_COMPRESS;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      scan_q <= scan_d;
      pack_q <= pack_d;
      len_q  <= len_d;
      if (accept) begin
        vl_q   <= vl_cap;
        mask_q <= mask_in;
        mode_q <= mode_in;
      end
    end
  end

  assign wr_en    = bit_set;
  assign scan_idx = scan_q[IW-1:0];
  assign pack_idx = pack_q[IW-1:0];
  assign busy     = busy_q;
  assign done     = done_q;
  assign len_out  = len_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R3
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (len_q <= vl_q));
  // R1
  pack_behind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pack_q <= scan_q));
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(vl_q) && $stable(mask_q) && $stable(mode_q)));
  // R10
  vl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= MAX_VL);
endmodule

// File: rtl/vmc_store.sv
module vmc_store
  import vmc_pkg::*;
#(
  parameter int NELEM = 64,
  parameter int DW    = 16,
  localparam int IW = $clog2(NELEM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                wr_en,
  input  vmc_mode_e           mode,
  input  logic [IW-1:0]       scan_idx,
  input  logic [IW-1:0]       pack_idx,
  input  logic [NELEM*DW-1:0] src_flat,
  input  logic [NELEM*DW-1:0] dst_flat_in,
  output logic [NELEM*DW-1:0] dst_flat_out
);
  logic [DW-1:0] src_q [NELEM];
  logic [DW-1:0] dst_q [NELEM];
  logic [IW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;

  always_comb begin
    if (mode == VMC_COMPRESS) begin
      wr_addr = pack_idx;
      rd_addr = scan_idx;
    end else begin
      wr_addr = scan_idx;
      rd_addr = pack_idx;
    end
    wr_data = src_q[rd_addr];
  end

  for (genvar g = 0; g < NELEM; g++) begin : g_elem
    logic hit;
    assign hit = wr_en & (wr_addr == IW'(g));
    always_ff @(posedge clk) begin
      if (load) begin
        src_q[g] <= src_flat[g*DW +: DW];
        dst_q[g] <= dst_flat_in[g*DW +: DW];
      end else if (hit) begin
        dst_q[g] <= wr_data;
      end
    end
    assign dst_flat_out[g*DW +: DW] = dst_q[g];
  end

  // R8
  load_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !wr_en);
endmodule

// File: rtl/vmask_permute.sv
module vmask_permute
  import vmc_pkg::*;
#(
  parameter int NELEM = 64,
  parameter int DW    = 16,
  localparam int IW = $clog2(NELEM),
  localparam int CW = IW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                mode,
  input  logic [CW-1:0]       vl,
  input  logic [NELEM-1:0]    mask,
  input  logic [NELEM*DW-1:0] src_data,
  input  logic [NELEM*DW-1:0] dst_prior,
  output logic                busy,
  output logic                done,
  output logic [NELEM*DW-1:0] dst_data,
  output logic [CW-1:0]       packed_len
);
  logic          accept, wr_en;
  logic [IW-1:0] scan_idx, pack_idx;
  vmc_mode_e     mode_q;

  vmc_ctrl #(.NELEM(NELEM)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode_in  (vmc_mode_e'(mode)),
    .vl_in    (vl),
    .mask_in  (mask),
    .accept   (accept),
    .wr_en    (wr_en),
    .scan_idx (scan_idx),
    .pack_idx (pack_idx),
    .mode_q   (mode_q),
    .busy     (busy),
    .done     (done),
    .len_out  (packed_len)
  );

  vmc_store #(.NELEM(NELEM), .DW(DW)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept),
    .wr_en        (wr_en),
    .mode         (mode_q),
    .scan_idx     (scan_idx),
    .pack_idx     (pack_idx),
    .src_flat     (src_data),
    .dst_flat_in  (dst_prior),
    .dst_flat_out (dst_data)
  );
endmodule

// File: tb/vmask_permute_bench.sv
module vmask_permute_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int DW = 8;
  localparam int CW = $clog2(NE) + 1;

  logic             clk = 1'b0;
  logic             rst_n, start, mode;
  logic [CW-1:0]    vl;
  logic [NE-1:0]    mask;
  logic [NE*DW-1:0] src_data, dst_prior, dst_data;
  logic             busy, done;
  logic [CW-1:0]    packed_len;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmask_permute #(.NELEM(NE), .DW(DW)) u_vmask_permute (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vl(vl),
    .mask(mask), .src_data(src_data), .dst_prior(dst_prior),
    .busy(busy), .done(done), .dst_data(dst_data), .packed_len(packed_len)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic m, input int rvl, input logic [NE-1:0] mk,
                        input int seed, input bit interfere);
    logic [DW-1:0] src_e [NE];
    logic [DW-1:0] exp_e [NE];
    int eff, k, cyc;
    string tag;
    for (int i = 0; i < NE; i++) begin
      src_e[i] = DW'(seed * 7 + i * 17 + 49);
      exp_e[i] = DW'(8'hC0 ^ (seed * 3 + i));
      src_data[i*DW +: DW]  = src_e[i];
      dst_prior[i*DW +: DW] = exp_e[i];
    end
    eff = (rvl > NE) ? NE : rvl;
    k = 0;
    for (int i = 0; i < eff; i++) begin
      if (mk[i]) begin
        if (m == 1'b0) exp_e[k] = src_e[i];
        else exp_e[i] = src_e[k];
        k++;
      end
    end
    mode = m; vl = CW'(rvl); mask = mk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    cyc = 0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (interfere && cyc == 1) begin
        // R8: conflicting request while busy
        start = 1'b1; mode = ~m; vl = CW'(3); mask = ~mk;
        src_data = ~src_data; dst_prior = ~dst_prior;
      end else if (interfere && cyc == 2) begin
        start = 1'b0;
      end
    end
    chk(cyc == eff + 1, interfere ? "R8 latency" : "R7 latency", cyc, eff + 1);
    chk(busy == 1'b0, "R7 idle at done", int'(busy), 0);
    if (interfere) tag = "R8";
    else if (rvl > NE) tag = "R10";
    else if (mk == '0) tag = "R11";
    else if ((mk >> eff) != '0) tag = "R6";
    else tag = "R3";
    chk(int'(packed_len) == k, tag, int'(packed_len), k);
    for (int i = 0; i < NE; i++) begin
      string et;
      if (interfere) et = "R8";
      else if (mk == '0) et = "R11";
      else if (m == 1'b0) et = (i < k) ? "R1" : "R2";
      else et = (i < eff && mk[i]) ? "R4" : "R5";
      chk(dst_data[i*DW +: DW] == exp_e[i], et,
          int'(dst_data[i*DW +: DW]), int'(exp_e[i]));
    end
    @(negedge clk);
    chk(done == 1'b0, "R7 single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; vl = '0; mask = '0;
    src_data = '0; dst_prior = '0;
    repeat (3) @(negedge clk);
    // R9
    chk(busy == 1'b0, "R9 busy", int'(busy), 0);
    chk(done == 1'b0, "R9 done", int'(done), 0);
    chk(packed_len == '0, "R9 len", int'(packed_len), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v <= 11; v++) begin
        int rv;
        rv = (v == 11) ? 15 : v;   // R10 for rv > 8
        for (int mk = 0; mk < 256; mk++) begin
          run_op(m[0], rv, NE'(mk), mk + rv, 1'b0);
        end
      end
    end
    // R8: interference on full-length scans
    run_op(1'b0, NE, 8'b1011_0010, 11, 1'b1);
    run_op(1'b1, NE, 8'b0110_1101, 23, 1'b1);
    run_op(1'b0, NE, 8'b1111_1111, 5, 1'b1);
    run_op(1'b1, NE, 8'b0000_0001, 9, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule